// File: doc/BRIEF.md
# Programmable Interval Timer

This block is a countdown timer sitting on a byte-wide I/O bus. Software programs a 16-bit period as two separate bytes, picks between a single run and a repeating run, and chooses whether the end of a count should request an interrupt. A built-in prescaler divides the system clock down to the counting tick, nominally 100 Hz. Each tick lowers an internal counter, and when a period runs out the block latches an end-of-count flag.

When the end-of-count interrupt is enabled, the latched flag drives an interrupt request toward the processor. The processor answers with an acknowledge strobe, and during that strobe the block places a software-programmed 8-bit interrupt type on a dedicated output. Reading the status register clears the flag and so ends the request. As an example, a control value of 0x07 with a period of 1000 ticks gives one interrupt every ten seconds at the nominal tick rate.

Register offsets: 0 period low byte, 1 period high byte, 2 control, 3 status, 4 interrupt type, 5 live count low byte, 6 live count high byte.

Top module: `ptimer_top`

## Requirements
- R1: After reset every register reads 0x00, `intReq` is low and `intType` is 0x00.
- R2: A write to offset 0 sets the low byte of the 16-bit period and a write to offset 1 sets the high byte. Both bytes read back unchanged.
- R3: The control register at offset 2 holds enable in bit 0, cyclic mode in bit 1 and interrupt enable in bit 2. Bits 7:3 always read as zero. An unmapped offset (7) reads 0x00.
- R4: Writing the control register with bit 0 set loads the counter from {high,low} and restarts the prescaler. The live count reads at offset 5 (low byte) and offset 6 (high byte).
- R5: While the timer is enabled, one tick occurs every TICK_DIV clock cycles and each tick lowers the counter by one. While the timer is disabled, the counter holds its value.
- R6: The tick that finds the counter at 1 or 0 is the end of the count. It sets status bit 0, which is END_COUNT at offset 3. For a period of N (N >= 1) this falls N*TICK_DIV cycles after the enabling write. A period of 0 ends on the first tick.
- R7: In cyclic mode the same end-of-count tick reloads the period, so events repeat every N ticks and the enable bit stays set.
- R8: In one-shot mode the end-of-count tick leaves the counter at 0 and clears the enable bit, so no further events occur.
- R9: `intReq` is high exactly while END_COUNT is set and the interrupt enable bit is set. END_COUNT still latches when the interrupt is disabled.
- R10: A read of offset 3 returns the flag and then clears it, together with `intReq`, on that clock edge. An end-of-count on the same edge wins, and the flag stays set.
- R11: The type register at offset 4 is read/write. `intType` carries its value while `intAck` is high and is 0x00 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| busAddr | input | 3 | Register offset |
| busWr | input | 1 | Write strobe, one cycle per write |
| busRd | input | 1 | Read strobe, one cycle per read |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Combinational read data of the addressed register |
| intAck | input | 1 | Interrupt acknowledge from the processor |
| intReq | output | 1 | Interrupt request |
| intType | output | 8 | Interrupt type, valid while intAck is high |

## Verification
Register writes take effect at the clock edge that samples the strobe. Read data is combinational, so the bench samples it before that edge, and a status read clears the flag at the same edge. With TICK_DIV set to 4, an enabling write at edge P0 gives counter decrements at P0+4k and an end-of-count at P0+4N. The bench therefore counts falling edges from the write and checks `intReq` one edge before and at the expected edge. `intType` is purely combinational on `intAck`, so the bench checks it within one half cycle without crossing an edge.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int COUNT_W = 2 * DATA_W;

  localparam logic [ADDR_W-1:0] OFS_LO   = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_HI   = 3'd1;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] OFS_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] OFS_TYPE = 3'd4;
  localparam logic [ADDR_W-1:0] OFS_CNTL = 3'd5;
  localparam logic [ADDR_W-1:0] OFS_CNTH = 3'd6;

  localparam int CTL_EN  = 0;
  localparam int CTL_CYC = 1;
  localparam int CTL_IE  = 2;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wrCtrl;
    logic wrType;
    logic rdStatus;
  } strobes_t;
endpackage

// File: rtl/ptimer_prescale.sv
module ptimer_prescale #(
  parameter int TICK_DIV = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic restart,
  output logic tick
);
  localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PRE_W-1:0] LAST = PRE_W'(TICK_DIV - 1);

  logic [PRE_W-1:0] preCnt;

  assign tick = run && (preCnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      preCnt <= '0;
    end else if (!run || restart || tick) begin
      preCnt <= '0;
    end else begin
      preCnt <= preCnt + PRE_W'(1);
    end
  end
endmodule

// File: rtl/ptimer_ctrl.sv
module ptimer_ctrl
  import ptimer_pkg::*;
(
  input  logic [ADDR_W-1:0]  busAddr,
  input  logic               busWr,
  input  logic               busRd,
  input  logic [COUNT_W-1:0] reloadVal,
  input  logic [2:0]         ctrlBits,
  input  logic               endFlag,
  input  logic [DATA_W-1:0]  typeReg,
  input  logic [COUNT_W-1:0] countVal,
  output strobes_t           stb,
  output logic [DATA_W-1:0]  busRdata
);
  always_comb begin
    stb          = '0;
    stb.wrLo     = busWr && (busAddr == OFS_LO);
    stb.wrHi     = busWr && (busAddr == OFS_HI);
    stb.wrCtrl   = busWr && (busAddr == OFS_CTRL);
    stb.wrType   = busWr && (busAddr == OFS_TYPE);
    stb.rdStatus = busRd && (busAddr == OFS_STAT);
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      OFS_LO:   busRdata = reloadVal[DATA_W-1:0];
      OFS_HI:   busRdata = reloadVal[COUNT_W-1:DATA_W];
      OFS_CTRL: busRdata = {{(DATA_W-3){1'b0}}, ctrlBits};
      OFS_STAT: busRdata = {{(DATA_W-1){1'b0}}, endFlag};
      OFS_TYPE: busRdata = typeReg;
      OFS_CNTL: busRdata = countVal[DATA_W-1:0];
      OFS_CNTH: busRdata = countVal[COUNT_W-1:DATA_W];
      default:  busRdata = '0;
    endcase
  end
endmodule

// File: rtl/ptimer_datapath.sv
module ptimer_datapath
  import ptimer_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  strobes_t           stb,
  input  logic [DATA_W-1:0]  wdata,
  input  logic               tick,
  output logic [COUNT_W-1:0] reloadVal,
  output logic [2:0]         ctrlBits,
  output logic [COUNT_W-1:0] countVal,
  output logic               endFlag,
  output logic [DATA_W-1:0]  typeReg,
  output logic               intReq
);
  logic enBit, cycBit, ieBit;
  logic atLast, endEvt;

  assign ctrlBits = {ieBit, cycBit, enBit};
  assign atLast   = (countVal <= COUNT_W'(1));
  assign endEvt   = tick && enBit && !stb.wrCtrl && atLast;
  assign intReq   = endFlag && ieBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reloadVal <= '0;
      typeReg   <= '0;
    end else begin
      if (stb.wrLo)   reloadVal[DATA_W-1:0]       <= wdata;
      if (stb.wrHi)   reloadVal[COUNT_W-1:DATA_W] <= wdata;
      if (stb.wrType) typeReg                     <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enBit    <= 1'b0;
      cycBit   <= 1'b0;
      ieBit    <= 1'b0;
      countVal <= '0;
    end else if (stb.wrCtrl) begin
      enBit  <= wdata[CTL_EN];
      cycBit <= wdata[CTL_CYC];
      ieBit  <= wdata[CTL_IE];
      if (wdata[CTL_EN]) countVal <= reloadVal;
    end else if (tick && enBit) begin
      if (atLast) begin
        if (cycBit) begin
          countVal <= reloadVal;
        end else begin
          countVal <= '0;
          enBit    <= 1'b0;
        end
      end else begin
        countVal <= countVal - COUNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)            endFlag <= 1'b0;
    else if (endEvt)       endFlag <= 1'b1;
    else if (stb.rdStatus) endFlag <= 1'b0;
  end
endmodule

// File: rtl/ptimer_top.sv
module ptimer_top
  import ptimer_pkg::*;
#(
  parameter int TICK_DIV = 500000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              intAck,
  output logic              intReq,
  output logic [DATA_W-1:0] intType
);
  strobes_t           stb;
  logic [COUNT_W-1:0] reloadVal;
  logic [COUNT_W-1:0] countVal;
  logic [2:0]         ctrlBits;
  logic               endFlag;
  logic [DATA_W-1:0]  typeReg;
  logic               tickPulse;

  ptimer_ctrl u_ctrl (
    .busAddr  (busAddr),
    .busWr    (busWr),
    .busRd    (busRd),
    .reloadVal(reloadVal),
    .ctrlBits (ctrlBits),
    .endFlag  (endFlag),
    .typeReg  (typeReg),
    .countVal (countVal),
    .stb      (stb),
    .busRdata (busRdata)
  );

  ptimer_prescale #(.TICK_DIV(TICK_DIV)) u_prescale (
    .clk    (clk),
    .rst_n  (rst_n),
    .run    (ctrlBits[CTL_EN]),
    .restart(stb.wrCtrl),
    .tick   (tickPulse)
  );

  ptimer_datapath u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .stb      (stb),
    .wdata    (busWdata),
    .tick     (tickPulse),
    .reloadVal(reloadVal),
    .ctrlBits (ctrlBits),
    .countVal (countVal),
    .endFlag  (endFlag),
    .typeReg  (typeReg),
    .intReq   (intReq)
  );

  assign intType = intAck ? typeReg : '0;
endmodule

// File: rtl/ptimer_checker.sv
module ptimer_checker
  import ptimer_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [ADDR_W-1:0]  busAddr,
  input logic               busWr,
  input logic               busRd,
  input logic               intAck,
  input logic [DATA_W-1:0]  intType,
  input logic               tick,
  input logic [2:0]         ctrlBits,
  input logic [COUNT_W-1:0] countVal,
  input logic               endFlag
);
  logic ctrlWrite;
  assign ctrlWrite = busWr && (busAddr == OFS_CTRL);

  assert_tick_enabled_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> ctrlBits[CTL_EN]);

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(tick) && !$past(busWr)) |-> $stable(countVal));

  assert_flag_from_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(endFlag) |-> $past(tick));

  assert_cyclic_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && ctrlBits[CTL_CYC] && !ctrlWrite) |-> ctrlBits[CTL_EN]);

  assert_oneshot_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tick && !ctrlBits[CTL_CYC] && (countVal <= COUNT_W'(1)) && !ctrlWrite)
      |-> (!ctrlBits[CTL_EN] && (countVal == '0)));

  assert_read_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busRd && (busAddr == OFS_STAT) && !tick) |-> !endFlag);

  assert_type_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (intAck && $past(intAck) && !$past(busWr)) |-> $stable(intType));
endmodule

bind ptimer_top ptimer_checker u_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .busAddr (busAddr),
  .busWr   (busWr),
  .busRd   (busRd),
  .intAck  (intAck),
  .intType (intType),
  .tick    (tickPulse),
  .ctrlBits(ctrlBits),
  .countVal(countVal),
  .endFlag (endFlag)
);

// File: tb/ptimer_top_bench.sv
module ptimer_top_bench;
  localparam int DIV = 4;
  localparam int NV  = 16;
  // entry: bit 11 = read(1)/write(0), bits 10:8 = offset, bits 7:0 = data / expected
  localparam logic [11:0] VECS [0:NV-1] = '{
    12'h200, 12'hB00, 12'hC00, 12'h800, 12'hD00, 12'hE00,
    12'h034, 12'h112, 12'h834, 12'h912,
    12'h2FA, 12'hA02,
    12'h45A, 12'hC5A, 12'hF00, 12'h200
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] busAddr = '0;
  logic       busWr = 1'b0;
  logic       busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       intAck = 1'b0;
  logic       intReq;
  logic [7:0] intType;

  int checkCount = 0;
  int failCount  = 0;
  logic [7:0] rv;

  always #10 clk = ~clk;

  ptimer_top #(.TICK_DIV(DIV)) u_ptimer_top (
    .clk(clk), .rst_n(rst_n), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .intAck(intAck), .intReq(intReq),
    .intType(intType)
  );

  function automatic string reqOf(input logic [2:0] a, input bit afterReset);
    if (!afterReset)           return "R1";
    if (a == 3'd0 || a == 3'd1) return "R2";
    if (a == 3'd4)              return "R11";
    return "R3";
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checkCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [2:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic rdReg(input logic [2:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdata;
    @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    waitEdges(3);
    rst_n = 1'b1;
    waitEdges(1);
    check("R1 intReq", intReq, 0);
    check("R1 intType", intType, 0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][11]) begin
        rdReg(VECS[i][10:8], rv);
        check(reqOf(VECS[i][10:8], i > 5), rv, VECS[i][7:0]);
      end else begin
        wrReg(VECS[i][10:8], VECS[i][7:0]);
      end
    end

    // R4: enabling write loads counter with 0x1234
    wrReg(3'd2, 8'h01);
    rdReg(3'd5, rv); check("R4 count low", rv, 8'h34);
    rdReg(3'd6, rv); check("R4 count high", rv, 8'h12);
    wrReg(3'd2, 8'h00);

    // cyclic, interrupt enabled, period 3
    wrReg(3'd0, 8'd3);
    wrReg(3'd1, 8'd0);
    wrReg(3'd2, 8'h07);                       // P0
    rdReg(3'd5, rv); check("R4 loaded", rv, 3);
    waitEdges(2);
    rdReg(3'd5, rv); check("R5 before tick", rv, 3);
    rdReg(3'd5, rv); check("R5 after tick", rv, 2);
    waitEdges(6);
    check("R6 not yet", intReq, 0);           // after P11
    waitEdges(1);
    check("R6 end at N*DIV", intReq, 1);      // after P12
    rdReg(3'd5, rv); check("R7 reloaded", rv, 3);
    rdReg(3'd3, rv); check("R10 status set", rv, 8'h01);
    check("R10 cleared", intReq, 0);          // after P14
    waitEdges(9);
    check("R7 no early event", intReq, 0);    // after P23
    waitEdges(1);
    check("R7 second event", intReq, 1);      // after P24
    rdReg(3'd2, rv); check("R7 enable kept", rv, 8'h07);

    intAck = 1'b1;
    #1 check("R11 type on ack", intType, 8'h5A);
    intAck = 1'b0;
    #1 check("R11 type idle", intType, 0);

    waitEdges(10);                            // after P35
    rdReg(3'd3, rv); check("R10 read at event", rv, 8'h01);
    check("R10 event wins", intReq, 1);
    rdReg(3'd3, rv); check("R10 flag kept", rv, 8'h01);
    check("R10 now cleared", intReq, 0);

    // one-shot, interrupt enabled
    wrReg(3'd2, 8'h05);                       // Q0
    waitEdges(11);
    check("R8 not yet", intReq, 0);
    waitEdges(1);
    check("R8 end event", intReq, 1);
    rdReg(3'd2, rv); check("R8 enable cleared", rv, 8'h04);
    rdReg(3'd5, rv); check("R8 count zero", rv, 0);
    rdReg(3'd3, rv); check("R8 status", rv, 8'h01);
    waitEdges(20);
    rdReg(3'd3, rv); check("R8 no further event", rv, 0);

    // period 0, interrupt disabled
    wrReg(3'd0, 8'd0);
    wrReg(3'd2, 8'h01);                       // S0
    waitEdges(4);
    check("R9 no request when disabled", intReq, 0);
    rdReg(3'd3, rv); check("R6 period zero ends on first tick", rv, 8'h01);
    rdReg(3'd3, rv); check("R10 status after clear", rv, 0);

    // hold while disabled
    wrReg(3'd0, 8'd5);
    wrReg(3'd2, 8'h03);                       // T0
    waitEdges(5);
    wrReg(3'd2, 8'h00);
    rdReg(3'd5, rv); check("R5 count at stop", rv, 4);
    waitEdges(20);
    rdReg(3'd5, rv); check("R5 count held", rv, 4);
    rdReg(3'd3, rv); check("R5 no event while stopped", rv, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end
endmodule